// File: doc/BRIEF.md
# Programmable Asynchronous Memory Read Sequencer

This block runs single read accesses to an external asynchronous static memory. Each chip select owns a set of timing fields: the read strobe has a setup and a pulse length, the chip select has its own setup and pulse length, and a total cycle length bounds the access. Every field is counted in controller clock cycles from the first cycle of the access. The two strobes are decoded from separate windows over one shared cycle counter. Neither strobe is derived from the other, and the block never checks which of them rises first.

A per-chip-select mode bit selects the strobe whose rising edge marks the sampling point. The data word present on the bus in the last low cycle of that strobe is captured, and a one-cycle valid pulse is issued with it. A zero pulse length is raised to one cycle and flagged. The effective cycle length is never shorter than either strobe's setup plus pulse. The address and byte selects are latched when a request is accepted and stay fixed for the whole access.

Top module: `amr_seq`

## Requirements
- R1: A request on `req_valid` is accepted only in a cycle where `busy` is 0. `busy` is 1 from the next cycle for exactly the effective cycle length, then returns to 0. Requests made while `busy` is 1 are ignored.
- R2: Number the busy cycles of an access k = 0, 1, 2, ... Then `mem_rd_n` is 0 exactly in cycles k with rs <= k < rs + rp, where rs is the read-strobe setup and rp the clamped read-strobe pulse.
- R3: Bit `req_cs` of `mem_cs_n` is 0 exactly in cycles k with css <= k < css + cp, using the chip-select setup and clamped pulse. All other bits stay 1, and at most one bit is ever 0.
- R4: With mode bit 1, `rd_data` takes the `mem_din` value present in cycle k = rs + rp - 1. `rd_valid` is 1 for exactly one cycle, the cycle in which `mem_rd_n` has just returned to 1.
- R5: With mode bit 0, capture happens in the same way in cycle k = css + cp - 1, and `rd_valid` coincides with `mem_cs_n` returning to all ones.
- R6: A read-strobe or chip-select pulse field of 0 is used as 1. `cfg_zero_err` is 1 for one cycle, the first busy cycle of that access.
- R7: The effective cycle length is the largest of the programmed cycle length, rs + rp and css + cp.
- R8: `mem_addr` equals the accepted `req_addr` and `mem_bs_n` equals the inverse of the accepted `req_be` throughout the access. Both hold their values after it ends.
- R9: During and after reset, `mem_rd_n` is 1, `mem_cs_n` is all ones, and `busy`, `rd_valid` and `cfg_zero_err` are 0.
- R10: Timing fields and mode bits are taken at acceptance. Changes made to them during an access have no effect on that access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Read request |
| req_cs | input | CSW (2) | Chip select index of the request |
| req_addr | input | AW (24) | Read address |
| req_be | input | BW (2) | Active-high byte selects |
| cfg_rd_setup | input | NCS*TW (24) | Read-strobe setup per chip select, field g at bits g*TW |
| cfg_rd_pulse | input | NCS*TW (24) | Read-strobe pulse per chip select |
| cfg_cs_setup | input | NCS*TW (24) | Chip-select setup per chip select |
| cfg_cs_pulse | input | NCS*TW (24) | Chip-select pulse per chip select |
| cfg_cycle | input | NCS*TW (24) | Total read cycle per chip select |
| cfg_rd_mode | input | NCS (4) | 1: read strobe controls sampling, 0: chip select does |
| mem_din | input | DW (16) | Data bus from memory |
| busy | output | 1 | Access in progress |
| mem_rd_n | output | 1 | Active-low read strobe |
| mem_cs_n | output | NCS (4) | Active-low chip selects |
| mem_addr | output | AW (24) | Latched address |
| mem_bs_n | output | BW (2) | Active-low latched byte selects |
| rd_data | output | DW (16) | Captured read word |
| rd_valid | output | 1 | One-cycle valid with rd_data |
| cfg_zero_err | output | 1 | Zero pulse field was clamped |

## Verification
Two events can fall in the same cycle: the data sampling point and the final busy cycle. This happens when the controlling strobe's setup plus pulse equals the effective cycle length. The bench programs exactly that case and holds `req_valid` high, so the next access is accepted in the cycle where `rd_valid` appears. A reference model compares every cycle, so a wrong capture or a lost or early acceptance is reported as a mismatch on `rd_data`, `rd_valid` or `busy`.

// File: rtl/amr_pkg.sv
package amr_pkg;

  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_RUN  = 1'b1
  } seq_state_e;

  // A zero pulse is not allowed; raise it to one cycle.
  function automatic int unsigned pulse_fix(input int unsigned v);
    return (v == 0) ? 1 : v;
  endfunction

  function automatic int unsigned max3(input int unsigned a,
                                       input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

  // Count k lies in the window [start, start+len).
  function automatic logic in_window(input int unsigned k,
                                     input int unsigned start,
                                     input int unsigned len);
    return (k >= start) && (k < start + len);
  endfunction

  // Count k is the final cycle of the window.
  function automatic logic window_last(input int unsigned k,
                                       input int unsigned start,
                                       input int unsigned len);
    return (k + 1) == (start + len);
  endfunction

endpackage

// File: rtl/amr_cfg_sel.sv
module amr_cfg_sel
  import amr_pkg::*;
#(
  parameter int NCS = 4,
  parameter int TW  = 6,
  parameter int CSW = 2,
  parameter int CW  = 7
) (
  input  logic [NCS*TW-1:0] rd_setup_v,
  input  logic [NCS*TW-1:0] rd_pulse_v,
  input  logic [NCS*TW-1:0] cs_setup_v,
  input  logic [NCS*TW-1:0] cs_pulse_v,
  input  logic [NCS*TW-1:0] cycle_v,
  input  logic [NCS-1:0]    mode_v,
  input  logic [CSW-1:0]    sel,
  output logic [CW-1:0]     rs_o,
  output logic [CW-1:0]     rp_o,
  output logic [CW-1:0]     css_o,
  output logic [CW-1:0]     cp_o,
  output logic [CW-1:0]     eff_o,
  output logic              mode_o,
  output logic              zero_o
);

  logic [TW-1:0] rs_a  [NCS];
  logic [TW-1:0] rp_a  [NCS];
  logic [TW-1:0] css_a [NCS];
  logic [TW-1:0] cp_a  [NCS];
  logic [TW-1:0] cyc_a [NCS];

  for (genvar g = 0; g < NCS; g++) begin : g_unpack
    assign rs_a[g]  = rd_setup_v[g*TW +: TW];
    assign rp_a[g]  = rd_pulse_v[g*TW +: TW];
    assign css_a[g] = cs_setup_v[g*TW +: TW];
    assign cp_a[g]  = cs_pulse_v[g*TW +: TW];
    assign cyc_a[g] = cycle_v[g*TW +: TW];
  end

  always_comb begin
    rs_o   = CW'(rs_a[sel]);
    css_o  = CW'(css_a[sel]);
    rp_o   = CW'(pulse_fix(32'(rp_a[sel])));
    cp_o   = CW'(pulse_fix(32'(cp_a[sel])));
    eff_o  = CW'(max3(32'(cyc_a[sel]),
                      32'(rs_o) + 32'(rp_o),
                      32'(css_o) + 32'(cp_o)));
    mode_o = mode_v[sel];
    zero_o = (rp_a[sel] == '0) || (cp_a[sel] == '0);
  end

endmodule

// File: rtl/amr_window.sv
module amr_window
  import amr_pkg::*;
#(
  parameter int CW = 7
) (
  input  logic          active,
  input  logic [CW-1:0] cnt,
  input  logic [CW-1:0] start,
  input  logic [CW-1:0] len,
  output logic          low,
  output logic          closing
);

  always_comb begin
    low     = active && in_window(32'(cnt), 32'(start), 32'(len));
    closing = active && window_last(32'(cnt), 32'(start), 32'(len));
  end

endmodule

// File: rtl/amr_capture.sv
module amr_capture #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fire,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout,
  output logic          vld
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dout <= '0;
      vld  <= 1'b0;
    end else begin
      vld <= fire;
      if (fire) dout <= din;
    end
  end

endmodule

// File: rtl/amr_seq.sv
module amr_seq
  import amr_pkg::*;
#(
  parameter int NCS = 4,
  parameter int AW  = 24,
  parameter int DW  = 16,
  parameter int TW  = 6,
  localparam int CSW = (NCS > 1) ? $clog2(NCS) : 1,
  localparam int BW  = DW / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [CSW-1:0]    req_cs,
  input  logic [AW-1:0]     req_addr,
  input  logic [BW-1:0]     req_be,
  input  logic [NCS*TW-1:0] cfg_rd_setup,
  input  logic [NCS*TW-1:0] cfg_rd_pulse,
  input  logic [NCS*TW-1:0] cfg_cs_setup,
  input  logic [NCS*TW-1:0] cfg_cs_pulse,
  input  logic [NCS*TW-1:0] cfg_cycle,
  input  logic [NCS-1:0]    cfg_rd_mode,
  input  logic [DW-1:0]     mem_din,
  output logic              busy,
  output logic              mem_rd_n,
  output logic [NCS-1:0]    mem_cs_n,
  output logic [AW-1:0]     mem_addr,
  output logic [BW-1:0]     mem_bs_n,
  output logic [DW-1:0]     rd_data,
  output logic              rd_valid,
  output logic              cfg_zero_err
);

  localparam int CW = TW + 1;

  seq_state_e     state;
  logic [CW-1:0]  cnt;
  logic [CSW-1:0] cs_q;
  logic [AW-1:0]  addr_q;
  logic [BW-1:0]  be_q;
  logic [CW-1:0]  rs_q, rp_q, css_q, cp_q, eff_q;
  logic           mode_q;
  logic           err_q;

  logic [CW-1:0]  sel_rs, sel_rp, sel_css, sel_cp, sel_eff;
  logic           sel_mode, sel_zero;

  // Named internal events, also observed by the checker
  logic seq_active;
  logic accept;
  logic final_cycle;
  logic rd_low, rd_close;
  logic cs_low, cs_close;
  logic sample_ev;
  logic lat_mode;

  assign seq_active  = (state == SEQ_RUN);
  assign accept      = (state == SEQ_IDLE) && req_valid;
  assign final_cycle = seq_active && (cnt == eff_q - 1'b1);
  assign lat_mode    = mode_q;

  amr_cfg_sel #(.NCS(NCS), .TW(TW), .CSW(CSW), .CW(CW)) u_sel (
    .rd_setup_v (cfg_rd_setup),
    .rd_pulse_v (cfg_rd_pulse),
    .cs_setup_v (cfg_cs_setup),
    .cs_pulse_v (cfg_cs_pulse),
    .cycle_v    (cfg_cycle),
    .mode_v     (cfg_rd_mode),
    .sel        (req_cs),
    .rs_o       (sel_rs),
    .rp_o       (sel_rp),
    .css_o      (sel_css),
    .cp_o       (sel_cp),
    .eff_o      (sel_eff),
    .mode_o     (sel_mode),
    .zero_o     (sel_zero)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= SEQ_IDLE;
      cnt    <= '0;
      cs_q   <= '0;
      addr_q <= '0;
      be_q   <= '0;
      rs_q   <= '0;
      rp_q   <= CW'(1);
      css_q  <= '0;
      cp_q   <= CW'(1);
      eff_q  <= CW'(1);
      mode_q <= 1'b1;
      err_q  <= 1'b0;
    end else begin
      err_q <= accept && sel_zero;
      if (accept) begin
        state  <= SEQ_RUN;
        cnt    <= '0;
        cs_q   <= req_cs;
        addr_q <= req_addr;
        be_q   <= req_be;
        rs_q   <= sel_rs;
        rp_q   <= sel_rp;
        css_q  <= sel_css;
        cp_q   <= sel_cp;
        eff_q  <= sel_eff;
        mode_q <= sel_mode;
      end else if (final_cycle) begin
        state <= SEQ_IDLE;
      end else if (seq_active) begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  amr_window #(.CW(CW)) u_rd_win (
    .active  (seq_active),
    .cnt     (cnt),
    .start   (rs_q),
    .len     (rp_q),
    .low     (rd_low),
    .closing (rd_close)
  );

  amr_window #(.CW(CW)) u_cs_win (
    .active  (seq_active),
    .cnt     (cnt),
    .start   (css_q),
    .len     (cp_q),
    .low     (cs_low),
    .closing (cs_close)
  );

  // Only the latched mode bit picks the sampling strobe.
  assign sample_ev = mode_q ? rd_close : cs_close;

  amr_capture #(.DW(DW)) u_cap (
    .clk   (clk),
    .rst_n (rst_n),
    .fire  (sample_ev),
    .din   (mem_din),
    .dout  (rd_data),
    .vld   (rd_valid)
  );

  for (genvar g = 0; g < NCS; g++) begin : g_csn
    assign mem_cs_n[g] = !(cs_low && (cs_q == CSW'(g)));
  end

  assign busy         = seq_active;
  assign mem_rd_n     = !rd_low;
  assign mem_addr     = addr_q;
  assign mem_bs_n     = ~be_q;
  assign cfg_zero_err = err_q;

endmodule

// File: rtl/amr_seq_chk.sv
module amr_seq_chk #(
  parameter int NCS = 4,
  parameter int AW  = 24,
  parameter int BW  = 2
) (
  input logic           clk,
  input logic           rst_n,
  input logic           req_valid,
  input logic           busy,
  input logic           mem_rd_n,
  input logic [NCS-1:0] mem_cs_n,
  input logic [AW-1:0]  mem_addr,
  input logic [BW-1:0]  mem_bs_n,
  input logic           rd_valid,
  input logic           lat_mode
);

  p_start_req_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(req_valid));

  p_one_cs_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~mem_cs_n) <= 1);

  p_valid_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);

  p_rd_edge_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && lat_mode) |-> $rose(mem_rd_n));

  p_cs_edge_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !lat_mode) |-> $rose(&mem_cs_n));

  p_addr_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(mem_addr) && $stable(mem_bs_n)));

  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (mem_rd_n && (&mem_cs_n)));

endmodule

bind amr_seq amr_seq_chk #(.NCS(NCS), .AW(AW), .BW(BW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .busy      (busy),
  .mem_rd_n  (mem_rd_n),
  .mem_cs_n  (mem_cs_n),
  .mem_addr  (mem_addr),
  .mem_bs_n  (mem_bs_n),
  .rd_valid  (rd_valid),
  .lat_mode  (lat_mode)
);

// File: tb/sim_amr_seq.sv
`timescale 1ns/1ps
module sim_amr_seq;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [1:0]  req_cs = '0;
  logic [23:0] req_addr = '0;
  logic [1:0]  req_be = '0;
  logic [23:0] cfg_rd_setup = '0, cfg_rd_pulse = '0, cfg_cs_setup = '0;
  logic [23:0] cfg_cs_pulse = '0, cfg_cycle = '0;
  logic [3:0]  cfg_rd_mode = '0;
  logic [15:0] mem_din = '0;
  logic        busy, mem_rd_n, rd_valid, cfg_zero_err;
  logic [3:0]  mem_cs_n;
  logic [23:0] mem_addr;
  logic [1:0]  mem_bs_n;
  logic [15:0] rd_data;

  always #10 clk = ~clk;

  amr_seq u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_cs(req_cs),
    .req_addr(req_addr), .req_be(req_be), .cfg_rd_setup(cfg_rd_setup),
    .cfg_rd_pulse(cfg_rd_pulse), .cfg_cs_setup(cfg_cs_setup),
    .cfg_cs_pulse(cfg_cs_pulse), .cfg_cycle(cfg_cycle),
    .cfg_rd_mode(cfg_rd_mode), .mem_din(mem_din), .busy(busy),
    .mem_rd_n(mem_rd_n), .mem_cs_n(mem_cs_n), .mem_addr(mem_addr),
    .mem_bs_n(mem_bs_n), .rd_data(rd_data), .rd_valid(rd_valid),
    .cfg_zero_err(cfg_zero_err)
  );

  int n_run = 0;
  int n_fail = 0;
  string scen = "";
  bit done = 0;

  // bench-side timing tables, one entry per chip select
  int t_rs[4], t_rp[4], t_css[4], t_cp[4], t_cyc[4];
  bit t_mode[4];

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s act=%0h exp=%0h at %0t", tag, scen, act, exp, $time);
    end
  endtask

  task automatic set_cfg(input int cs, input int rs, input int rp, input int css,
                         input int cp, input int cyc, input bit md);
    t_rs[cs] = rs; t_rp[cs] = rp; t_css[cs] = css; t_cp[cs] = cp;
    t_cyc[cs] = cyc; t_mode[cs] = md;
    for (int g = 0; g < 4; g++) begin
      cfg_rd_setup[g*6 +: 6] = 6'(t_rs[g]);
      cfg_rd_pulse[g*6 +: 6] = 6'(t_rp[g]);
      cfg_cs_setup[g*6 +: 6] = 6'(t_css[g]);
      cfg_cs_pulse[g*6 +: 6] = 6'(t_cp[g]);
      cfg_cycle[g*6 +: 6]    = 6'(t_cyc[g]);
      cfg_rd_mode[g]         = t_mode[g];
    end
  endtask

  // ---------------- reference model ----------------
  int m_busy = 0, m_k = 0, m_cs = 0, m_rs = 0, m_rp = 1, m_css = 0, m_cp = 1, m_eff = 1;
  int m_mode = 1;
  logic [23:0] m_addr = '0;
  logic [1:0]  m_be = '0;
  logic [15:0] m_rdata = '0;
  int m_rv = 0, m_rv_mode = 1, m_err = 0;

  always @(posedge clk) begin
    int samp, rv_n, err_n, a, b, c;
    if (!rst_n) begin
      m_busy = 0; m_k = 0; m_rv = 0; m_err = 0; m_addr = '0; m_be = '0; m_rdata = '0;
    end else begin
      samp = m_mode ? (m_rs + m_rp) : (m_css + m_cp);
      rv_n = (m_busy != 0) && (m_k == samp - 1);
      if (rv_n) begin m_rdata = mem_din; m_rv_mode = m_mode; end
      err_n = 0;
      if (m_busy != 0) begin
        if (m_k == m_eff - 1) m_busy = 0; else m_k++;
      end else if (req_valid) begin
        m_cs = req_cs;
        m_rs = t_rs[m_cs]; m_css = t_css[m_cs];
        m_rp = (t_rp[m_cs] == 0) ? 1 : t_rp[m_cs];
        m_cp = (t_cp[m_cs] == 0) ? 1 : t_cp[m_cs];
        a = t_cyc[m_cs]; b = m_rs + m_rp; c = m_css + m_cp;
        m_eff = a; if (b > m_eff) m_eff = b; if (c > m_eff) m_eff = c;
        m_mode = t_mode[m_cs];
        err_n = (t_rp[m_cs] == 0) || (t_cp[m_cs] == 0);
        m_addr = req_addr; m_be = req_be;
        m_busy = 1; m_k = 0;
      end
      m_rv = rv_n; m_err = err_n;
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    logic e_rd;
    logic [3:0] e_cs;
    if (rst_n && !done) begin
      e_rd = !((m_busy != 0) && m_k >= m_rs && m_k < m_rs + m_rp);
      e_cs = 4'hF;
      if ((m_busy != 0) && m_k >= m_css && m_k < m_css + m_cp) e_cs[m_cs] = 1'b0;
      chk(busy == (m_busy != 0), "R1 R7 busy", busy, m_busy);
      chk(mem_rd_n == e_rd, "R2 rd_n", mem_rd_n, e_rd);
      chk(mem_cs_n == e_cs, "R3 cs_n", mem_cs_n, e_cs);
      chk(rd_valid == (m_rv != 0), m_rv_mode ? "R4 valid" : "R5 valid", rd_valid, m_rv);
      if (m_rv != 0)
        chk(rd_data == m_rdata, m_rv_mode ? "R4 data" : "R5 data", rd_data, m_rdata);
      chk(cfg_zero_err == (m_err != 0), "R6 zero flag", cfg_zero_err, m_err);
      chk(mem_addr == m_addr, "R8 addr", mem_addr, m_addr);
      chk(mem_bs_n == ~m_be, "R8 bs_n", mem_bs_n, ~m_be);
    end
  end

  // memory data bus: a new word every cycle
  initial begin
    forever begin
      @(negedge clk);
      mem_din = 16'($urandom);
    end
  end

  task automatic do_read(input int cs, input logic [23:0] addr, input logic [1:0] be);
    @(negedge clk);
    while (busy) @(negedge clk);
    req_valid = 1'b1; req_cs = 2'(cs); req_addr = addr; req_be = be;
    @(negedge clk);
    req_valid = 1'b0;
    req_addr = ~addr; req_be = ~be;
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    for (int g = 0; g < 4; g++) set_cfg(g, 0, 1, 0, 1, 1, 1'b1);
    repeat (3) begin
      @(negedge clk);
      chk(mem_rd_n == 1'b1 && mem_cs_n == 4'hF, "R9 strobes in reset", {mem_rd_n, mem_cs_n}, 5'h1F);
      chk(!busy && !rd_valid && !cfg_zero_err, "R9 flags in reset", {busy, rd_valid, cfg_zero_err}, 0);
    end
    rst_n = 1'b1;

    scen = "[mode1 basic]";
    set_cfg(0, 1, 3, 0, 5, 8, 1'b1);
    do_read(0, 24'h00A5A5, 2'b11);

    scen = "[mode0 cs first]";
    set_cfg(1, 2, 4, 1, 2, 9, 1'b0);
    do_read(1, 24'h123456, 2'b01);

    scen = "[zero pulses]";
    set_cfg(2, 0, 0, 0, 0, 3, 1'b1);
    do_read(2, 24'h0F0F0F, 2'b10);

    scen = "[short cycle]";
    set_cfg(3, 3, 4, 2, 6, 2, 1'b0);
    do_read(3, 24'hFEDCBA, 2'b11);

    // sampling edge on the final busy cycle with a request held high
    scen = "[sample at end, held request R1]";
    set_cfg(0, 2, 4, 0, 3, 6, 1'b1);
    @(negedge clk);
    req_valid = 1'b1; req_cs = 2'd0; req_addr = 24'h0000C3; req_be = 2'b11;
    repeat (25) @(negedge clk);
    req_valid = 1'b0;
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);

    // configuration rewritten during an access
    scen = "[R10 mid-access change]";
    set_cfg(1, 1, 2, 0, 4, 7, 1'b0);
    @(negedge clk);
    req_valid = 1'b1; req_cs = 2'd1; req_addr = 24'h777777; req_be = 2'b10;
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    set_cfg(1, 5, 9, 3, 1, 2, 1'b1);
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);

    scen = "[random]";
    for (int i = 0; i < 60; i++) begin
      int cs;
      cs = int'($urandom_range(0, 3));
      set_cfg(cs, int'($urandom_range(0, 7)), int'($urandom_range(0, 7)),
              int'($urandom_range(0, 7)), int'($urandom_range(0, 7)),
              int'($urandom_range(0, 20)), 1'($urandom_range(0, 1)));
      do_read(cs, 24'($urandom), 2'($urandom));
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog R1 act=busy exp=idle");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule